// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens a raster image along the line-to-line direction. Pixels arrive one per valid cycle, in raster order, with a fixed line length. Two chained line delays give the filter three vertically aligned taps. The incoming pixel is the lower neighbour (B). The output of the first delay is the centre pixel (N). The output of the second delay is the upper neighbour (A). For each column the filter forms the second difference 2N − (A + B), scales it by an unsigned coefficient K and adds the result back to the centre pixel. The result is rounded and then clamped to the pixel range.

K has 4 integer and 4 fractional bits, so K = coef/16. For each pixel the block uses the coef value that is present with that pixel's valid. The arithmetic runs in two register stages. A small controller tracks the write column and the fill state of the line buffers. It has three states. `ST_FILL_FIRST` means no line is stored yet, so the centre tap is forced to 0. `ST_FILL_SECOND` means one line is stored, so the centre pixel passes through unchanged. `ST_FILTER` is the full filter. The transition from first to second, and from second to filter, takes place on a valid pixel at the last column. The filter state is left only by reset. In every state, the output for the pixel that arrives on line L is the filtered pixel of line L−1 in the same column.

Top module: `vlap_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and out_pix is 0.
- R2: out_valid is asserted exactly two clock cycles after each cycle with in_valid high, and only then. Cycles with in_valid low do not advance the column or change the line buffers.
- R3: While the first line after reset is streaming, each output pixel is 0.
- R4: While the second line is streaming, each output pixel equals the pixel in the same column of the first line, unchanged.
- R5: From the third line on, out_pix = clamp(floor((16·N + coef·(2N − A − B) + 8) / 16)). A is the pixel of the line two lines back, N is the pixel of the line one line back, and B is the incoming pixel, all in the same column.
- R6: With coef = 0, the output equals N.
- R7: A result below 0 is output as 0.
- R8: A result above 1023 is output as 1023.
- R9: A fractional result of exactly one half rounds toward plus infinity. This holds for both positive and negative second differences.
- R10: The coef applied to a pixel is the value present in its in_valid cycle. Changes to coef in idle cycles have no effect.
- R11: The controller moves from ST_FILL_FIRST to ST_FILL_SECOND, and from ST_FILL_SECOND to ST_FILTER, only on a valid pixel at column LINE_LEN−1. It leaves ST_FILTER only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming pixel qualifier |
| in_pix | input | PIX_W | Incoming pixel (lower tap B) |
| coef | input | K_W | Unsigned coefficient, K = coef / 2^K_FRAC |
| out_valid | output | 1 | Corrected pixel qualifier |
| out_pix | output | PIX_W | Corrected pixel |

## Verification
The bench targets both clamp limits. It sets up a column where A = B = 0 and N = 1023 with the largest coef, which checks the upper limit. It sets up a column where A = B = 1023 and N = 0, which checks the lower limit. A design without saturation would wrap these results to small or large garbage values. Two columns land exactly on a half, one with a positive second difference and one with a negative one. Rounding half toward zero, or truncating, would be off by one on one of them.

Idle gaps are inserted mid-line, and coef and in_pix are set to junk values during them. A design that advanced its column, or sampled coef late, would misalign the taps or apply the wrong K. The state changes at the last column of lines 0 and 1 are checked pixel by pixel. A transition that came early or late would show up as a zero or an unfiltered pixel in the wrong place.

// File: rtl/vlap_pkg.sv
package vlap_pkg;

    typedef enum logic [1:0] {
        ST_FILL_FIRST  = 2'd0,
        ST_FILL_SECOND = 2'd1,
        ST_FILTER      = 2'd2
    } vlap_state_e;

endpackage

// File: rtl/vlap_line_delay.sv
module vlap_line_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    logic [W-1:0] mem [DEPTH];

    // Read the old entry before it is overwritten: the delay is exactly DEPTH pixels.
    assign dout = mem[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= din;
        end
    end

endmodule

// File: rtl/vlap_ctrl.sv
module vlap_ctrl
    import vlap_pkg::*;
#(
    parameter int LINE_LEN = 1024,
    parameter int AW       = $clog2(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic [AW-1:0] col,
    output vlap_state_e   state,
    output logic          pass_through,
    output logic          zero_center
);

    localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

    vlap_state_e state_nx;
    logic        line_end;

    assign line_end = in_valid && (col == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
        end else if (in_valid) begin
            col <= line_end ? '0 : col + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL_FIRST;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL_FIRST:  if (line_end) state_nx = ST_FILL_SECOND;
            ST_FILL_SECOND: if (line_end) state_nx = ST_FILTER;
            ST_FILTER:      state_nx = ST_FILTER;
            default:        state_nx = ST_FILL_FIRST;
        endcase
    end

    always_comb begin
        pass_through = (state != ST_FILTER);
        zero_center  = (state == ST_FILL_FIRST);
    end

    assert_filter_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILTER) |=> (state == ST_FILTER));

    assert_first_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL_FIRST && !(in_valid && col == LAST)) |=> (state == ST_FILL_FIRST));

    assert_col_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col <= LAST);

    assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(col));

endmodule

// File: rtl/vlap_arith.sv
module vlap_arith #(
    parameter int PIX_W  = 10,
    parameter int K_W    = 8,
    parameter int K_FRAC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             pass_through,
    input  logic             zero_center,
    input  logic [PIX_W-1:0] a_pix,
    input  logic [PIX_W-1:0] n_pix,
    input  logic [PIX_W-1:0] b_pix,
    input  logic [K_W-1:0]   coef,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam int DW    = PIX_W + 3;
    localparam int ACC_W = DW + K_W + PIX_W;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (K_FRAC - 1);
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

    logic [PIX_W-1:0]        n_eff;
    logic signed [DW-1:0]    diff_c;

    logic                    s1_valid, s1_pass;
    logic [PIX_W-1:0]        s1_n;
    logic [K_W-1:0]          s1_k;
    logic signed [DW-1:0]    s1_diff;

    logic signed [ACC_W-1:0] prod_c, center_c, rnd_c;
    logic [PIX_W-1:0]        result_c;

    // Stage 1: second difference 2N - (A + B)
    always_comb begin
        n_eff  = zero_center ? '0 : n_pix;
        diff_c = $signed({3'b000, n_eff} <<< 1) - $signed({3'b000, a_pix})
                 - $signed({3'b000, b_pix});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_pass  <= 1'b0;
            s1_n     <= '0;
            s1_k     <= '0;
            s1_diff  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_pass <= pass_through;
                s1_n    <= n_eff;
                s1_k    <= coef;
                s1_diff <= diff_c;
            end
        end
    end

    // Stage 2: scale, add back, round half up, clamp
    always_comb begin
        prod_c   = ACC_W'(s1_diff) * ACC_W'($signed({1'b0, s1_k}));
        center_c = $signed({{(ACC_W - PIX_W){1'b0}}, s1_n}) <<< K_FRAC;
        rnd_c    = (center_c + prod_c + HALF) >>> K_FRAC;
        if (rnd_c < 0) begin
            result_c = '0;
        end else if (rnd_c > PMAX) begin
            result_c = '1;
        end else begin
            result_c = rnd_c[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_pix <= s1_pass ? s1_n : result_c;
            end
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);

    assert_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_pass || s1_k == '0)) |=> (out_pix == $past(s1_n)));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(out_pix));

endmodule

// File: rtl/vlap_filter.sv
module vlap_filter
    import vlap_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int LINE_LEN = 1024,
    parameter int K_W      = 8,
    parameter int K_FRAC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [K_W-1:0]   coef,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam int AW = $clog2(LINE_LEN);

    logic [AW-1:0]    col;
    vlap_state_e      state;
    logic             pass_through, zero_center;
    logic [PIX_W-1:0] cur_tap, prev_tap;

    vlap_ctrl #(.LINE_LEN(LINE_LEN), .AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .col          (col),
        .state        (state),
        .pass_through (pass_through),
        .zero_center  (zero_center)
    );

    vlap_line_delay #(.W(PIX_W), .DEPTH(LINE_LEN), .AW(AW)) u_dly_cur (
        .clk  (clk),
        .we   (in_valid),
        .addr (col),
        .din  (in_pix),
        .dout (cur_tap)
    );

    vlap_line_delay #(.W(PIX_W), .DEPTH(LINE_LEN), .AW(AW)) u_dly_prev (
        .clk  (clk),
        .we   (in_valid),
        .addr (col),
        .din  (cur_tap),
        .dout (prev_tap)
    );

    vlap_arith #(.PIX_W(PIX_W), .K_W(K_W), .K_FRAC(K_FRAC)) u_arith (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .pass_through (pass_through),
        .zero_center  (zero_center),
        .a_pix        (prev_tap),
        .n_pix        (cur_tap),
        .b_pix        (in_pix),
        .coef         (coef),
        .out_valid    (out_valid),
        .out_pix      (out_pix)
    );

    assert_second_needs_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL_SECOND) |-> $past(state) != ST_FILTER);

endmodule

// File: tb/vlap_filter_bench.sv
module vlap_filter_bench;

    localparam int PIX_W = 10;
    localparam int LEN   = 8;
    localparam int NLINE = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic [7:0]       coef = '0;
    logic             out_valid;
    logic [PIX_W-1:0] out_pix;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    run_chk = 1'b0;
    bit    done = 1'b0;
    int    hist[$];
    int    due_q[$];
    int    val_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    vlap_filter #(.PIX_W(PIX_W), .LINE_LEN(LEN)) u_vlap_filter (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_pix (in_pix),
        .coef (coef), .out_valid (out_valid), .out_pix (out_pix)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung (actual cycle %0d, expected completion)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int pix_of(int ln, int c);
        if (c == 0 && ln == 1) return 0;
        if (c == 0 && ln == 2) return 1023;
        if (c == 0 && ln == 3) return 0;
        if (c == 1 && ln == 2) return 1023;
        if (c == 1 && ln == 3) return 0;
        if (c == 1 && ln == 4) return 1023;
        if (c == 2 && ln == 3) return 0;
        if (c == 2 && (ln == 4 || ln == 5)) return 1;
        if (c == 3 && (ln == 4 || ln == 5)) return 1;
        if (c == 3 && ln == 6) return 2;
        return (ln * 97 + c * 41 + 5) % 1024;
    endfunction

    function automatic int k_of(int ln, int c);
        if (c < 2) return 255;
        if (c == 2 || c == 3) return 8;
        if (c == 4) return 0;
        return (ln * 13 + c * 7) % 256;
    endfunction

    task automatic push_pix(int p, int k);
        int i, ln, c, e, v;
        string t;
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = PIX_W'(p);
        coef     = 8'(k);
        i  = hist.size();
        ln = i / LEN;
        c  = i % LEN;
        if (ln == 0) begin
            e = 0; t = "R3";
        end else if (ln == 1) begin
            e = hist[i - LEN]; t = (c == LEN - 1) ? "R11" : "R4";
        end else begin
            v = 16 * hist[i - LEN] + k * (2 * hist[i - LEN] - hist[i - 2 * LEN] - p) + 8;
            e = v >>> 4;
            if (e < 0) e = 0;
            if (e > 1023) e = 1023;
            if (ln == 2 && c == 0)      t = "R11";
            else if (ln == 3 && c == 0) t = "R8";
            else if (ln == 4 && c == 1) t = "R7";
            else if ((ln == 5 && c == 2) || (ln == 6 && c == 3)) t = "R9";
            else if (k == 0)            t = "R6";
            else if (c % 2 == 1)        t = "R10";
            else                        t = "R5";
        end
        hist.push_back(p);
        due_q.push_back(cyc + 2);
        val_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pix   = '1;
            coef     = 8'hFF;
        end
    endtask

    always @(negedge clk) begin
        if (run_chk) begin
            bit ev;
            ev = (due_q.size() > 0) && (due_q[0] == cyc);
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL R2 out_valid at cycle %0d: actual %0b expected %0b", cyc, out_valid, ev);
            end
            if (ev) begin
                checks++;
                if (out_pix !== PIX_W'(val_q[0])) begin
                    errors++;
                    $display("FAIL %s out_pix at cycle %0d: actual %0d expected %0d",
                             tag_q[0], cyc, out_pix, val_q[0]);
                end
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_pix !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %0b/%0d expected 0/0", out_valid, out_pix);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_pix !== '0) begin
            errors++;
            $display("FAIL R1 after reset: actual %0b/%0d expected 0/0", out_valid, out_pix);
        end
        run_chk = 1'b1;
        for (int ln = 0; ln < NLINE; ln++) begin
            for (int c = 0; c < LEN; c++) begin
                push_pix(pix_of(ln, c), k_of(ln, c));
                if ((ln + c) % 5 == 3) idle(1);
                if (ln == 3 && c == 4) idle(4);
            end
        end
        idle(6);
        checks++;
        if (due_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending outputs: actual %0d expected 0", due_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule